// File: doc/BRIEF.md
# FIFO Data Checksum Unit

This block keeps a running 16-bit CRC over the bytes that pass through the command/response data buffer of a byte-wide FIFO interface. Each accepted byte is folded into the CRC in one clock cycle. When the buffer offset returns to zero, signalled by a buffer-clear strobe, the CRC restarts from zero. The CRC therefore always covers exactly the bytes from buffer position 0 up to the current offset.

Software sees the result through a checksum readout and a one-bit checksum enable. The readout holds the CRC with its two bytes exchanged. It can be read as a 32-bit register, one byte at a time in little-endian order, and its upper two bytes are always zero. While the enable is clear, the readout shows zero. The CRC keeps running in the background, so setting the enable shows the checksum of the whole buffer at once. Buffer storage and the bus bridge sit outside this block.

Top module: `fifo_csum_unit`

## Requirements
- R1: The CRC is the reflected CCITT form: polynomial 0x8408, initial value 0, data bits taken LSB first, no final XOR. One byte is folded in per cycle in which `byte_vld_i` is high. The ASCII bytes "123456789" give a CRC register of 0x2189.
- R2: After `rst_ni` is released, the CRC register is 0 and `csum_en_o` is 0.
- R3: A cycle with `buf_clr_i` high and `byte_vld_i` low leaves the CRC at 0. If both are high in the same cycle, the CRC becomes the CRC of that single byte, starting from 0.
- R4: A cycle with both `byte_vld_i` and `buf_clr_i` low leaves the CRC unchanged.
- R5: `csum_o[15:8]` equals CRC bits 7:0, and `csum_o[7:0]` equals CRC bits 15:8.
- R6: A cycle with `en_we_i` high stores `en_wdata_i[0]` as the enable. Bits 7:1 of `en_wdata_i` are ignored. `csum_en_o` reads back the stored bit and changes only on a write.
- R7: While the enable is 0, `csum_o` and `rd_byte_o` read 0. The CRC keeps accumulating, so after the enable is set, `csum_o` shows the CRC of every byte since the last clear.
- R8: The readout that includes a byte is valid right after the clock edge that accepts the byte. It is correct for every byte of a back-to-back stream.
- R9: `rd_byte_o` returns byte `rd_idx_i` of the 32-bit value {16'h0, `csum_o`}: index 0 gives `csum_o[7:0]`, index 1 gives `csum_o[15:8]`, and indices 2 and 3 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | A data byte enters the buffer this cycle |
| byte_i | input | 8 | Data byte |
| buf_clr_i | input | 1 | Buffer offset returns to zero |
| en_we_i | input | 1 | Write strobe for the checksum enable |
| en_wdata_i | input | 8 | Write data for the enable; only bit 0 is kept |
| rd_idx_i | input | 2 | Byte index into the 32-bit checksum readout |
| csum_o | output | 16 | Byte-swapped CRC, or zero while disabled |
| rd_byte_o | output | 8 | Selected byte of the checksum readout |
| csum_en_o | output | 1 | Stored checksum enable |

## Verification
The hardest case to reach is a buffer clear that falls in the same cycle as a data byte. There, the restart and the fold-in must combine, rather than one dropping the other. The bench sweeps all 256 byte values through this combined cycle. For each one it compares the swapped readout against a bit-serial model that uses a different shift-and-feedback form, and it reads a rotating byte index. A second hard case is a CRC that is hidden while accumulating: bytes are streamed with the enable clear, and then the enable is set. The readout must show the full hidden value, with no extra cycle.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned REG_W    = 32;
  localparam logic [CRC_W-1:0] CCITT_REFL = 16'h8408;
endpackage

// File: rtl/csum_crc_step.sv
module csum_crc_step #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned PAD_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_i ^ {{PAD_W{1'b0}}, data_i};

  // one LSB-first shift per data bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/csum_crc_acc.sv
module csum_crc_acc #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q, base, nxt;

  // a clear restarts from INIT; a byte in the same cycle is the first of the new buffer
  assign base = clr_i ? INIT : crc_q;

  csum_crc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i (base),
    .data_i(data_i),
    .crc_o (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (vld_i) crc_q <= nxt;
    else if (clr_i) crc_q <= INIT;
  end

  assign crc_o = crc_q;

  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !vld_i |=> crc_q == INIT); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !vld_i |=> $stable(crc_q)); // R4
endmodule

// File: rtl/csum_en_reg.sv
module csum_en_reg #(
  parameter int unsigned WDATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WDATA_W-1:0] wdata_i,
  output logic               en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (we_i) en_q <= wdata_i[0];
  end

  assign en_o = en_q;

  AST_EN_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q)); // R6
  AST_EN_TAKES_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> en_q == $past(wdata_i[0])); // R6
endmodule

// File: rtl/fifo_csum_unit.sv
module fifo_csum_unit
  import csum_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned SUM_W  = CRC_W,
  parameter int unsigned RD_W   = REG_W,
  parameter logic [SUM_W-1:0] POLY = CCITT_REFL,
  localparam int unsigned NBYTES = RD_W / DATA_W,
  localparam int unsigned IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              buf_clr_i,
  input  logic              en_we_i,
  input  logic [DATA_W-1:0] en_wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [SUM_W-1:0]  csum_o,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              csum_en_o
);
  localparam int unsigned SUM_BYTES = SUM_W / DATA_W;

  logic [SUM_W-1:0] crc, swapped;
  logic [RD_W-1:0]  rd_word;
  logic             en;

  csum_crc_acc #(.DATA_W(DATA_W), .CRC_W(SUM_W), .POLY(POLY), .INIT('0)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (byte_vld_i),
    .data_i(byte_i),
    .clr_i (buf_clr_i),
    .crc_o (crc)
  );

  csum_en_reg #(.WDATA_W(DATA_W)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (en_we_i),
    .wdata_i(en_wdata_i),
    .en_o   (en)
  );

  // reverse byte order of the CRC
  for (genvar b = 0; b < SUM_BYTES; b++) begin : g_swap
    assign swapped[b*DATA_W +: DATA_W] = crc[(SUM_BYTES-1-b)*DATA_W +: DATA_W];
  end

  assign csum_o    = en ? swapped : '0;
  assign rd_word   = {{(RD_W-SUM_W){1'b0}}, csum_o};
  assign rd_byte_o = rd_word[rd_idx_i*DATA_W +: DATA_W];
  assign csum_en_o = en;

  AST_GATED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csum_en_o |-> csum_o == '0 && rd_byte_o == '0); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_idx_i) >= SUM_BYTES |-> rd_byte_o == '0); // R9
  AST_LOW_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == '0 |-> rd_byte_o == csum_o[DATA_W-1:0]); // R9
endmodule

// File: tb/fifo_csum_unit_test.sv
`timescale 1ns/1ps
module fifo_csum_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, clr = 1'b0, we = 1'b0;
  logic [7:0]  din = '0, wdat = '0;
  logic [1:0]  idx = '0;
  logic [15:0] csum;
  logic [7:0]  rbyte;
  logic        en;
  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] model = '0;

  always #2.5 clk = ~clk;

  fifo_csum_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .byte_i(din), .buf_clr_i(clr),
    .en_we_i(we), .en_wdata_i(wdat), .rd_idx_i(idx),
    .csum_o(csum), .rd_byte_o(rbyte), .csum_en_o(en)
  );

  function automatic logic [15:0] fold(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c  = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic [15:0] sw(logic [15:0] c);
    return {c[7:0], c[15:8]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the next rising edge
  task automatic cyc(logic v, logic c, logic [7:0] d);
    @(negedge clk);
    vld = v; clr = c; din = d;
    @(posedge clk);
    if (c) model = 16'h0;
    if (v) model = fold(model, d);
    #1;
    vld = 1'b0; clr = 1'b0;
  endtask

  task automatic wr_en(logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wdat = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_up();
  end

  initial begin
    logic [7:0] msg [9];
    logic [7:0] lfsr;
    logic [15:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 enable after reset", {31'h0, en}, 32'h0);
    wr_en(8'h01);
    chk("R2 crc zero after reset", {16'h0, csum}, 32'h0);
    chk("R6 readback set", {31'h0, en}, 32'h1);
    wr_en(8'hFE);
    chk("R6 bits 7:1 ignored", {31'h0, en}, 32'h0);
    wr_en(8'h03);
    chk("R6 bit0 set again", {31'h0, en}, 32'h1);

    // exhaustive: clear and byte in the same cycle, rotating read index
    for (int b = 0; b < 256; b++) begin
      @(negedge clk); idx = 2'(b);
      cyc(1'b1, 1'b1, 8'(b));
      chk("R3 clear with byte", {16'h0, csum}, {16'h0, sw(fold(16'h0, 8'(b)))});
      chk("R9 byte select", {24'h0, rbyte},
          {24'h0, (b % 4 == 0) ? csum[7:0] : (b % 4 == 1) ? csum[15:8] : 8'h00});
    end

    cyc(1'b0, 1'b1, 8'hAA);
    chk("R3 clear alone", {16'h0, csum}, 32'h0);

    msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, msg[i]);
    chk("R1 known answer", {16'h0, csum}, 32'h8921);
    chk("R5 swap vs model", {16'h0, csum}, {16'h0, sw(model)});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idx = 2'(k);
      #1;
      chk("R9 word bytes", {24'h0, rbyte}, {24'h0, (k == 0) ? 8'h21 : (k == 1) ? 8'h89 : 8'h00});
    end

    held = csum;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'(i * 37));
    chk("R4 idle hold", {16'h0, csum}, {16'h0, held});

    // hidden accumulation while disabled
    wr_en(8'h00);
    chk("R7 disabled reads zero", {16'h0, csum}, 32'h0);
    idx = 2'd1;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 8'(8'hC3 + i));
    chk("R7 zero while streaming", {16'h0, csum}, 32'h0);
    chk("R7 byte read zero", {24'h0, rbyte}, 32'h0);
    wr_en(8'h01);
    chk("R7 full value on enable", {16'h0, csum}, {16'h0, sw(model)});

    // back-to-back stream, every byte checked right after its edge
    cyc(1'b0, 1'b1, 8'h00);
    lfsr = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(1'b1, (i == 150), lfsr);
      chk("R8 stream", {16'h0, csum}, {16'h0, sw(model)});
    end

    finish_up();
  end
endmodule